// File: doc/BRIEF.md
# Nibble Command Interpreter

This block turns a byte stream of commands into register writes on an output bus. Commands come from two places, a keypad encoder and a serial receiver. The block merges them with a bitwise OR and does not tell them apart. Each byte carries a command class in its upper four bits and a payload in its lower four bits.

Data commands shift a hex digit into a four-digit queue. The newest digit enters at the least significant end, so the digits typed first end up as the most significant. Action commands clear the queue, request a serial dump, or copy the queued 16-bit word to either the address register or the data register. Each copy is signalled by a one-cycle write strobe that comes with the register number and the value.

To write 0xABCD into register 2, the byte sequence is 0x12, 0x22, 0x1A, 0x1B, 0x1C, 0x1D, 0x23.

Top module: `nibcmd_top`

## Requirements
- R1: After a synchronous reset, the queue holds zero, the stored address is zero, the output value is zero and all strobes are low.
- R2: A valid byte whose upper nibble is 0x1 shifts its lower nibble into the low end of the queue. The older digits move up one place and the oldest digit is dropped. Four digits A, B, C, D therefore give 0xABCD.
- R3: If fewer than four digits are entered after a clear or reset, the value is right-aligned with zeros above it. If more than four are entered, only the last four are kept.
- R4: Byte 0x22 raises `addr_wr` for exactly the cycle after it is accepted. In that cycle `wr_value` equals the queue, and `reg_num` takes the low nibble of the queue and keeps it until the next 0x22.
- R5: Byte 0x23 raises `data_wr` for exactly the cycle after it is accepted. In that cycle `wr_value` equals the queue and `reg_num` shows the stored address.
- R6: A transfer does not change the queue, so a repeated transfer sends the same value. `wr_value` holds its last written value between writes.
- R7: Byte 0x21 clears the queue to zero.
- R8: Byte 0x24 raises `dump_req` for exactly the cycle after it is accepted.
- R9: The following bytes have no effect: action bytes with payload 0x0 or 0x5 to 0xF, and any byte whose upper nibble is neither 0x1 nor 0x2. This includes every byte with bit 7 set. Such a byte raises no strobe and leaves the queue and the address unchanged.
- R10: The command byte is the bitwise OR of the bytes from the sources whose valid is high, and it is accepted when either valid is high.
- R11: At most one of `addr_wr`, `data_wr` and `dump_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | Keypad byte strobe |
| key_byte | input | 8 | Keypad command byte |
| host_valid | input | 1 | Serial receiver byte strobe |
| host_byte | input | 8 | Serial receiver command byte |
| addr_wr | output | 1 | Address register write strobe |
| data_wr | output | 1 | Data register write strobe |
| wr_value | output | 16 | Value written by the latest strobe |
| reg_num | output | 4 | Stored register number |
| dump_req | output | 1 | Serial dump request pulse |

## Verification
The queue cannot be seen directly. A wrong digit order, a lost shift or a failed clear shows up only when the next 0x22 or 0x23 puts the queue on `wr_value`, one cycle after that byte. A corrupted stored address shows up on `reg_num` at once, and on the next data write. The reference model is compared against every output on every clock. Each transfer in the bench therefore exposes the whole queue within one cycle.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
    localparam int NIB_W   = 4;
    localparam int Q_DEPTH = 4;
    localparam int VAL_W   = NIB_W * Q_DEPTH;
    localparam int BYTE_W  = 2 * NIB_W;

    localparam logic [NIB_W-1:0] CLS_DATA = 4'h1;
    localparam logic [NIB_W-1:0] CLS_ACT  = 4'h2;

    localparam logic [NIB_W-1:0] ACT_CLEAR = 4'h1;
    localparam logic [NIB_W-1:0] ACT_WADDR = 4'h2;
    localparam logic [NIB_W-1:0] ACT_WDATA = 4'h3;
    localparam logic [NIB_W-1:0] ACT_DUMP  = 4'h4;

    typedef enum logic [2:0] {
        K_NONE,
        K_DATA,
        K_CLEAR,
        K_WADDR,
        K_WDATA,
        K_DUMP
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic [NIB_W-1:0] nib;
    } cmd_t;

    function automatic cmd_t decode_byte(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.nib  = b[NIB_W-1:0];
        c.kind = K_NONE;
        if (b[BYTE_W-1:NIB_W] == CLS_DATA) begin
            c.kind = K_DATA;
        end else if (b[BYTE_W-1:NIB_W] == CLS_ACT) begin
            case (b[NIB_W-1:0])
                ACT_CLEAR: c.kind = K_CLEAR;
                ACT_WADDR: c.kind = K_WADDR;
                ACT_WDATA: c.kind = K_WDATA;
                ACT_DUMP:  c.kind = K_DUMP;
                default:   c.kind = K_NONE;
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/nibcmd_merge.sv
module nibcmd_merge
    import nibcmd_pkg::*;
(
    input  logic              a_valid,
    input  logic [BYTE_W-1:0] a_byte,
    input  logic              b_valid,
    input  logic [BYTE_W-1:0] b_byte,
    output logic              m_valid,
    output logic [BYTE_W-1:0] m_byte
);
    always_comb begin
        m_valid = a_valid | b_valid;
        m_byte  = ({BYTE_W{a_valid}} & a_byte) | ({BYTE_W{b_valid}} & b_byte);
    end
endmodule

// File: rtl/nibcmd_decode.sv
module nibcmd_decode
    import nibcmd_pkg::*;
(
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output cmd_t              cmd
);
    always_comb begin
        cmd = decode_byte(in_byte);
        if (!in_valid) cmd.kind = K_NONE;
    end
endmodule

// File: rtl/nibcmd_queue.sv
module nibcmd_queue
    import nibcmd_pkg::*;
#(
    parameter int W     = NIB_W,
    parameter int DEPTH = Q_DEPTH,
    localparam int TOT  = W * DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         clear,
    input  logic [W-1:0] nib_in,
    output logic [TOT-1:0] word
);
    logic [W-1:0] slot [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic [W-1:0] next_nib;
            if (i == 0) begin : g_head
                assign next_nib = nib_in;
            end else begin : g_body
                assign next_nib = slot[i-1];
            end
            always_ff @(posedge clk) begin
                if (rst || clear) slot[i] <= '0;
                else if (push)    slot[i] <= next_nib;
            end
            assign word[i*W +: W] = slot[i];
        end
    endgenerate
endmodule

// File: rtl/nibcmd_top.sv
module nibcmd_top
    import nibcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_valid,
    input  logic [7:0]        key_byte,
    input  logic              host_valid,
    input  logic [7:0]        host_byte,
    output logic              addr_wr,
    output logic              data_wr,
    output logic [15:0]       wr_value,
    output logic [3:0]        reg_num,
    output logic              dump_req
);
    logic              m_valid;
    logic [BYTE_W-1:0] m_byte;
    cmd_t              cmd;
    logic [VAL_W-1:0]  q_word;

    nibcmd_merge u_merge (
        .a_valid (key_valid),
        .a_byte  (key_byte),
        .b_valid (host_valid),
        .b_byte  (host_byte),
        .m_valid (m_valid),
        .m_byte  (m_byte)
    );

    nibcmd_decode u_dec (
        .in_valid (m_valid),
        .in_byte  (m_byte),
        .cmd      (cmd)
    );

    nibcmd_queue #(.W(NIB_W), .DEPTH(Q_DEPTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .push   (cmd.kind == K_DATA),
        .clear  (cmd.kind == K_CLEAR),
        .nib_in (cmd.nib),
        .word   (q_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_wr  <= 1'b0;
            data_wr  <= 1'b0;
            dump_req <= 1'b0;
            wr_value <= '0;
            reg_num  <= '0;
        end else begin
            addr_wr  <= (cmd.kind == K_WADDR);
            data_wr  <= (cmd.kind == K_WDATA);
            dump_req <= (cmd.kind == K_DUMP);
            if (cmd.kind == K_WADDR) begin
                wr_value <= q_word;
                reg_num  <= q_word[NIB_W-1:0];
            end else if (cmd.kind == K_WDATA) begin
                wr_value <= q_word;
            end
        end
    end
endmodule

// File: rtl/nibcmd_checker.sv
module nibcmd_checker (
    input logic        clk,
    input logic        rst,
    input logic        key_valid,
    input logic [7:0]  key_byte,
    input logic        host_valid,
    input logic [7:0]  host_byte,
    input logic        addr_wr,
    input logic        data_wr,
    input logic [15:0] wr_value,
    input logic [3:0]  reg_num,
    input logic        dump_req
);
    logic       any_v;
    logic [7:0] any_b;
    assign any_v = key_valid | host_valid;
    assign any_b = (key_valid ? key_byte : 8'h00) | (host_valid ? host_byte : 8'h00);

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_wr, data_wr, dump_req}));

    p_addr_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (any_v && any_b == 8'h22) |=> (addr_wr && reg_num == wr_value[3:0]));

    p_data_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (any_v && any_b == 8'h23) |=> data_wr);

    p_dump_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (any_v && any_b == 8'h24) |=> dump_req);

    p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (any_v && any_b[7:4] != 4'h1 && any_b[7:4] != 4'h2)
            |=> !(addr_wr || data_wr || dump_req));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (any_v && any_b == 8'h21) ##1 (any_v && any_b == 8'h23) |=> wr_value == 16'h0000);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(addr_wr || data_wr) |-> $stable(wr_value));
endmodule

bind nibcmd_top nibcmd_checker i_chk (.*);

// File: tb/test_nibcmd_top.sv
module test_nibcmd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_valid = 1'b0;
    logic [7:0]  key_byte = 8'h00;
    logic        host_valid = 1'b0;
    logic [7:0]  host_byte = 8'h00;
    logic        addr_wr, data_wr, dump_req;
    logic [15:0] wr_value;
    logic [3:0]  reg_num;

    always #4 clk = ~clk;

    nibcmd_top i_nibcmd_top (.*);

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    logic [15:0] m_q = 0, m_val = 0;
    logic [3:0]  m_addr = 0;
    logic        m_a = 0, m_d = 0, m_p = 0;

    always @(posedge clk) begin
        logic       v;
        logic [7:0] b;
        v = key_valid | host_valid;
        b = (key_valid ? key_byte : 8'h00) | (host_valid ? host_byte : 8'h00);
        m_a = 0; m_d = 0; m_p = 0;
        if (rst) begin
            m_q = 0; m_val = 0; m_addr = 0;
        end else if (v) begin
            if (b[7:4] == 4'h1) m_q = {m_q[11:0], b[3:0]};
            else if (b[7:4] == 4'h2) begin
                case (b[3:0])
                    4'h1: m_q = 0;
                    4'h2: begin m_a = 1; m_val = m_q; m_addr = m_q[3:0]; end
                    4'h3: begin m_d = 1; m_val = m_q; end
                    4'h4: m_p = 1;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check(cur_req, {31'b0, addr_wr}, {31'b0, m_a}, "addr_wr");
        check(cur_req, {31'b0, data_wr}, {31'b0, m_d}, "data_wr");
        check(cur_req, {31'b0, dump_req}, {31'b0, m_p}, "dump_req");
        check(cur_req, {16'b0, wr_value}, {16'b0, m_val}, "wr_value");
        check(cur_req, {28'b0, reg_num}, {28'b0, m_addr}, "reg_num");
    end

    task automatic send_key(input logic [7:0] b);
        @(negedge clk);
        key_valid = 1; key_byte = b;
        @(negedge clk);
        key_valid = 0; key_byte = 8'h00;
    endtask

    task automatic send_host(input logic [7:0] b);
        @(negedge clk);
        host_valid = 1; host_byte = b;
        @(negedge clk);
        host_valid = 0; host_byte = 8'h00;
    endtask

    task automatic expect_now(input string req, input logic a, input logic d, input logic [15:0] val, input logic [3:0] rn);
        check(req, {31'b0, addr_wr}, {31'b0, a}, "spec addr_wr");
        check(req, {31'b0, data_wr}, {31'b0, d}, "spec data_wr");
        check(req, {16'b0, wr_value}, {16'b0, val}, "spec wr_value");
        check(req, {28'b0, reg_num}, {28'b0, rn}, "spec reg_num");
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        expect_now("R1", 0, 0, 16'h0000, 4'h0);
        rst = 0;
        // R2 R4 R5: register 2 gets 0xABCD
        cur_req = "R4";
        send_key(8'h12);
        @(negedge clk); key_valid = 1; key_byte = 8'h22;
        @(negedge clk); key_valid = 0; key_byte = 8'h00;
        expect_now("R4", 1, 0, 16'h0002, 4'h2);
        cur_req = "R2";
        send_key(8'h1A); send_key(8'h1B); send_key(8'h1C); send_key(8'h1D);
        cur_req = "R5";
        @(negedge clk); host_valid = 1; host_byte = 8'h23;
        @(negedge clk); host_valid = 0; host_byte = 8'h00;
        expect_now("R5", 0, 1, 16'hABCD, 4'h2);
        @(negedge clk);
        expect_now("R6", 0, 0, 16'hABCD, 4'h2);
        // R6 repeated transfer
        cur_req = "R6";
        send_host(8'h23);
        @(negedge clk);
        // R3 overflow keeps last four
        cur_req = "R3";
        send_key(8'h15);
        send_key(8'h23);
        expect_now("R3", 0, 1, 16'hBCD5, 4'h2);
        // R7 clear then fewer digits
        cur_req = "R7";
        send_key(8'h21);
        send_key(8'h23);
        expect_now("R7", 0, 1, 16'h0000, 4'h2);
        cur_req = "R3";
        send_key(8'h17); send_key(8'h1E);
        send_key(8'h23);
        expect_now("R3", 0, 1, 16'h007E, 4'h2);
        // R8 dump
        cur_req = "R8";
        @(negedge clk); key_valid = 1; key_byte = 8'h24;
        @(negedge clk); key_valid = 0; key_byte = 8'h00;
        check("R8", {31'b0, dump_req}, 32'd1, "dump pulse");
        @(negedge clk);
        check("R8", {31'b0, dump_req}, 32'd0, "dump one cycle");
        // R9 ignored bytes
        cur_req = "R9";
        send_key(8'h20); send_key(8'h25); send_key(8'h2F);
        send_key(8'h91); send_key(8'hA2); send_key(8'h03); send_key(8'h33);
        send_host(8'h23);
        expect_now("R9", 0, 1, 16'h007E, 4'h2);
        // R10 OR merge: 0x10 | 0x03 = 0x13
        cur_req = "R10";
        @(negedge clk);
        key_valid = 1; key_byte = 8'h10; host_valid = 1; host_byte = 8'h03;
        @(negedge clk);
        key_valid = 0; host_valid = 0; key_byte = 0; host_byte = 0;
        // 0x02 | 0x20 = 0x22
        @(negedge clk);
        key_valid = 1; key_byte = 8'h02; host_valid = 1; host_byte = 8'h20;
        @(negedge clk);
        key_valid = 0; host_valid = 0; key_byte = 0; host_byte = 0;
        expect_now("R10", 1, 0, 16'h07E3, 4'h3);
        // R11 back-to-back actions
        cur_req = "R11";
        send_key(8'h22);
        @(negedge clk); key_valid = 1; key_byte = 8'h23;
        @(negedge clk); key_byte = 8'h24;
        @(negedge clk); key_byte = 8'h22;
        @(negedge clk); key_valid = 0; key_byte = 0;
        // R1 reset mid-stream
        cur_req = "R1";
        send_key(8'h19);
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk);
        expect_now("R1", 0, 0, 16'h0000, 4'h0);
        rst = 0;
        send_key(8'h23);
        expect_now("R1", 0, 1, 16'h0000, 4'h0);
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule